// File: doc/BRIEF.md
# Static Memory Bus Controller

This block turns single requests from an on-chip initiator into access cycles on an off-chip asynchronous static-memory bus. The initiator presents a halfword address, write data, two byte enables and a read/write flag under a valid/ready handshake. The controller selects one of several active-low chip selects, runs a setup, strobe and hold sequence on the external pins, and returns a one-cycle ready pulse with the read data.

Every chip select has its own configuration on plain input pins: an enable, the value of the top address bits it answers to, a 16-bit or 8-bit data bus, an early or standard read strobe, and a count of 0 to 7 wait states. An external wait pin can stretch any strobe beyond that count. On an 8-bit device, a request that enables both bytes becomes two byte cycles, low byte first. The lower-byte select pin then carries address bit 0. The 16-bit data bus has separate input, output and output-enable signals.

Back-pressure rules: the initiator keeps `req_valid` and every request field stable from the cycle it raises `req_valid` until the cycle in which `req_ready` is high. The transfer completes in that cycle, and `rsp_rdata` is valid in that same cycle only. `req_ready` is never high outside this handshake.

Top module: `ext_sram_ctrl`

## Requirements
- R1: While reset is held, all chip selects, both byte selects and both strobes are high, the data output enable is low and `req_ready` is low.
- R2: A request goes to the lowest-numbered enabled chip select whose match value equals the top three halfword-address bits. At most one chip select is ever low. A request that matches no enabled chip select, or that has both byte enables clear, drives no chip select and no strobe. It completes with `req_ready` in the first cycle after it is seen, with read data zero.
- R3: Each external cycle has one setup cycle, then a strobe lasting 1 + W cycles for a wait count W, then one hold cycle. `req_ready` is high in the final hold cycle. For a single external cycle, it is high 3 + W cycles after the cycle in which the request was first seen.
- R4: Once the wait count is used up, each rising edge that samples `ext_wait` high adds one more strobe cycle.
- R5: An early-read chip select drives `ext_rd_n` low from the setup cycle through the strobe (2 + W cycles). A standard-read chip select drives it low only in the strobe (1 + W cycles). `ext_wr_n` is low only during the strobe of a write.
- R6: On a 16-bit chip select, `ext_ub_n` is the inverse of enable bit 1 and `ext_lb_n` is the inverse of enable bit 0. `ext_addr` is the request address, and all 16 data bits are written.
- R7: On an 8-bit chip select, `ext_ub_n` stays high and `ext_lb_n` gives the byte address bit: 0 for the low byte (data bits 7:0), 1 for the high byte (bits 15:8). The selected byte always travels on `ext_dout[7:0]` and `ext_din[7:0]`, and a read returns it in its own lane.
- R8: An 8-bit chip select with both enables set runs two external cycles, low byte first, and completes 6 + 2W cycles after the request is seen.
- R9: When `ext_wr_n` rises, chip select, address and write data stay unchanged and the output enable stays high for the hold cycle that follows.
- R10: `req_ready` is a single-cycle pulse. It is low in the cycle after a completion.
- R11: Read data is the value of `ext_din` at the rising edge that ends the strobe. Byte lanes whose enable is clear read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | One-cycle completion pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_haddr | input | 23 | Halfword address |
| req_be | input | 2 | Byte enables, bit 1 = high byte |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data, valid with req_ready |
| cfg_en | input | 8 | Chip select enable, one bit each |
| cfg_match | input | 24 | Three-bit match value per chip select |
| cfg_bus16 | input | 8 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_early | input | 8 | 1 = early read strobe |
| cfg_wait | input | 24 | Three-bit wait count per chip select |
| ext_cs_n | output | 8 | Active-low chip selects |
| ext_addr | output | 23 | External halfword address |
| ext_ub_n | output | 1 | Upper byte select |
| ext_lb_n | output | 1 | Lower byte select, or address bit 0 on 8-bit |
| ext_rd_n | output | 1 | Read strobe |
| ext_wr_n | output | 1 | Write strobe |
| ext_wait | input | 1 | External wait request |
| ext_din | input | 16 | Data bus in |
| ext_dout | output | 16 | Data bus out |
| ext_dout_en | output | 1 | Data bus output enable |

## Verification
The hardest state to reach is the boundary between the two halves of a split byte access. There the chip select stays low, the hold cycle of the low byte leads straight into a fresh setup for the high byte, and any slip in lane selection or in the ready pulse would go unseen at a single cycle. The stimulus reaches it through an 8-bit chip select with two wait states and both enables set, for both reads and writes. A bus model returns a different byte for each value of the byte address pin, and an upper lane of constant garbage shows whether a wrong lane was taken. Wait-pin stretching is reached by holding `ext_wait` high past the configured count and releasing it at a known cycle.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_SKIP   = 3'd4
  } sm_state_e;

  localparam int LANE_W = 8;
  localparam int DATA_W = 2 * LANE_W;
endpackage

// File: rtl/sm_cs_decode.sv
module sm_cs_decode #(
  parameter int NCS     = 8,
  parameter int MATCH_W = 3,
  parameter int IDX_W   = 3
) (
  input  logic [MATCH_W-1:0]     key,
  input  logic [NCS-1:0]         en,
  input  logic [NCS*MATCH_W-1:0] match,
  output logic                   hit,
  output logic [IDX_W-1:0]       idx
);
  logic [NCS-1:0] eq;

  for (genvar g = 0; g < NCS; g++) begin : g_cmp
    assign eq[g] = en[g] && (match[g*MATCH_W +: MATCH_W] == key);
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NCS - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/sm_wait_timer.sv
module sm_wait_timer #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              run,
  input  logic              ext_wait,
  output logic              done
);
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  // configured count first, then the external pin
  assign done = (cnt == '0) && !ext_wait;
endmodule

// File: rtl/sm_lane_map.sv
module sm_lane_map
  import sm_pkg::*;
(
  input  logic              bus16,
  input  logic [1:0]        be,
  input  logic              lane,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rdata_prev,
  output logic              ub_n,
  output logic              lb_n,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] rdata_next
);
  always_comb begin
    if (bus16) begin
      ub_n = ~be[1];
      lb_n = ~be[0];
      dout = wdata;
      rdata_next[DATA_W-1:LANE_W] = be[1] ? din[DATA_W-1:LANE_W] : rdata_prev[DATA_W-1:LANE_W];
      rdata_next[LANE_W-1:0]      = be[0] ? din[LANE_W-1:0]      : rdata_prev[LANE_W-1:0];
    end else begin
      ub_n = 1'b1;
      lb_n = lane;
      dout = {{LANE_W{1'b0}}, (lane ? wdata[DATA_W-1:LANE_W] : wdata[LANE_W-1:0])};
      if (lane) begin
        rdata_next = {din[LANE_W-1:0], rdata_prev[LANE_W-1:0]};
      end else begin
        rdata_next = {rdata_prev[DATA_W-1:LANE_W], din[LANE_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/ext_sram_ctrl.sv
module ext_sram_ctrl
  import sm_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int NCS     = 8,
  parameter int MATCH_W = 3,
  parameter int WAIT_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-2:0]      req_haddr,
  input  logic [1:0]             req_be,
  input  logic [15:0]            req_wdata,
  output logic [15:0]            rsp_rdata,
  input  logic [NCS-1:0]         cfg_en,
  input  logic [NCS*MATCH_W-1:0] cfg_match,
  input  logic [NCS-1:0]         cfg_bus16,
  input  logic [NCS-1:0]         cfg_early,
  input  logic [NCS*WAIT_W-1:0]  cfg_wait,
  output logic [NCS-1:0]         ext_cs_n,
  output logic [ADDR_W-2:0]      ext_addr,
  output logic                   ext_ub_n,
  output logic                   ext_lb_n,
  output logic                   ext_rd_n,
  output logic                   ext_wr_n,
  input  logic                   ext_wait,
  input  logic [15:0]            ext_din,
  output logic [15:0]            ext_dout,
  output logic                   ext_dout_en
);
  localparam int EA_W  = ADDR_W - 1;
  localparam int IDX_W = (NCS > 1) ? $clog2(NCS) : 1;

  sm_state_e state;

  logic              hit;
  logic [IDX_W-1:0]  sel_idx;
  logic [IDX_W-1:0]  cur_idx;
  logic              cur_bus16;
  logic              cur_early;
  logic [WAIT_W-1:0] cur_wait;
  logic              cur_write;
  logic [EA_W-1:0]   cur_addr;
  logic [1:0]        cur_be;
  logic [15:0]       cur_wdata;
  logic              lane;
  logic              more;
  logic [15:0]       rdata_q;
  logic [15:0]       rdata_next;
  logic              timer_done;
  logic              on_bus;
  logic              map_ub_n;
  logic              map_lb_n;
  logic [15:0]       map_dout;

  sm_cs_decode #(
    .NCS     (NCS),
    .MATCH_W (MATCH_W),
    .IDX_W   (IDX_W)
  ) u_dec (
    .key   (req_haddr[EA_W-1 -: MATCH_W]),
    .en    (cfg_en),
    .match (cfg_match),
    .hit   (hit),
    .idx   (sel_idx)
  );

  sm_wait_timer #(
    .WAIT_W (WAIT_W)
  ) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (state == ST_SETUP),
    .load_val (cur_wait),
    .run      (state == ST_STROBE),
    .ext_wait (ext_wait),
    .done     (timer_done)
  );

  sm_lane_map u_lane (
    .bus16      (cur_bus16),
    .be         (cur_be),
    .lane       (lane),
    .wdata      (cur_wdata),
    .din        (ext_din),
    .rdata_prev (rdata_q),
    .ub_n       (map_ub_n),
    .lb_n       (map_lb_n),
    .dout       (map_dout),
    .rdata_next (rdata_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_idx   <= '0;
      cur_bus16 <= 1'b1;
      cur_early <= 1'b0;
      cur_wait  <= '0;
      cur_write <= 1'b0;
      cur_addr  <= '0;
      cur_be    <= '0;
      cur_wdata <= '0;
      lane      <= 1'b0;
      more      <= 1'b0;
      rdata_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            rdata_q <= '0;
            if (!hit || (req_be == 2'b00)) begin
              state <= ST_SKIP;
            end else begin
              state     <= ST_SETUP;
              cur_idx   <= sel_idx;
              cur_bus16 <= cfg_bus16[sel_idx];
              cur_early <= cfg_early[sel_idx];
              cur_wait  <= cfg_wait[sel_idx*WAIT_W +: WAIT_W];
              cur_write <= req_write;
              cur_addr  <= req_haddr;
              cur_be    <= req_be;
              cur_wdata <= req_wdata;
              lane      <= cfg_bus16[sel_idx] ? 1'b0 : !req_be[0];
              more      <= !cfg_bus16[sel_idx] && (req_be == 2'b11);
            end
          end
        end
        ST_SETUP: state <= ST_STROBE;
        ST_STROBE: begin
          if (timer_done) begin
            state <= ST_HOLD;
            if (!cur_write) begin
              rdata_q <= rdata_next;
            end
          end
        end
        ST_HOLD: begin
          if (more) begin
            more  <= 1'b0;
            lane  <= 1'b1;
            state <= ST_SETUP;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_SKIP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign on_bus      = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign req_ready   = ((state == ST_HOLD) && !more) || (state == ST_SKIP);
  assign rsp_rdata   = rdata_q;
  assign ext_addr    = cur_addr;
  assign ext_cs_n    = on_bus ? ~(NCS'(1) << cur_idx) : '1;
  assign ext_ub_n    = on_bus ? map_ub_n : 1'b1;
  assign ext_lb_n    = on_bus ? map_lb_n : 1'b1;
  assign ext_rd_n    = !(!cur_write && ((state == ST_STROBE) || ((state == ST_SETUP) && cur_early)));
  assign ext_wr_n    = !(cur_write && (state == ST_STROBE));
  assign ext_dout_en = on_bus && cur_write;
  assign ext_dout    = map_dout;

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

  // R9
  wr_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_wr_n |-> (ext_cs_n != '1) && ext_dout_en);

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_wr_n) |-> ($stable(ext_cs_n) && $stable(ext_addr) && $stable(ext_dout) && ext_dout_en));

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R4
  wait_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_STROBE) && ext_wait) |=> (state == ST_STROBE));

  // R7
  narrow_ub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_cs_n != '1) && !cur_bus16) |-> ext_ub_n);
endmodule

// File: tb/ext_sram_ctrl_tb.sv
module ext_sram_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [22:0] req_haddr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rsp_rdata;
  logic [7:0]  cfg_en    = 8'b0000_1111;
  logic [23:0] cfg_match = {3'd0, 3'd0, 3'd0, 3'd0, 3'd1, 3'd2, 3'd1, 3'd0};
  logic [7:0]  cfg_bus16 = 8'b0000_1101;
  logic [7:0]  cfg_early = 8'b0000_0110;
  logic [23:0] cfg_wait  = {3'd0, 3'd0, 3'd0, 3'd0, 3'd5, 3'd3, 3'd2, 3'd0};
  logic [7:0]  ext_cs_n;
  logic [22:0] ext_addr;
  logic        ext_ub_n, ext_lb_n, ext_rd_n, ext_wr_n;
  logic        ext_wait = 1'b0;
  logic [15:0] ext_din;
  logic [15:0] ext_dout;
  logic        ext_dout_en;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  ext_sram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_haddr(req_haddr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .cfg_en(cfg_en),
    .cfg_match(cfg_match), .cfg_bus16(cfg_bus16), .cfg_early(cfg_early),
    .cfg_wait(cfg_wait), .ext_cs_n(ext_cs_n), .ext_addr(ext_addr),
    .ext_ub_n(ext_ub_n), .ext_lb_n(ext_lb_n), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .ext_wait(ext_wait), .ext_din(ext_din),
    .ext_dout(ext_dout), .ext_dout_en(ext_dout_en)
  );

  function automatic logic [7:0] pat(input logic [22:0] a, input logic b);
    return a[7:0] ^ (b ? 8'h3C : 8'h5A);
  endfunction

  // bus model: 16-bit devices return both bytes, 8-bit devices one byte per lb_n value
  always_comb begin
    ext_din = 16'hFFFF;
    for (int i = 0; i < 8; i++) begin
      if (!ext_cs_n[i]) begin
        if (cfg_bus16[i]) ext_din = {pat(ext_addr, 1'b1), pat(ext_addr, 1'b0)};
        else              ext_din = {8'hEE, pat(ext_addr, ext_lb_n)};
      end
    end
  end

  // bus monitor, sampled 1 ns after each rising edge
  int          strb_cnt, nwr, hold_bad;
  logic [7:0]  cs_seen;
  logic [63:0] wlog [2];
  logic        p_wr = 1'b1;
  logic [7:0]  p_cs = 8'hFF;
  logic [22:0] p_addr = '0;
  logic [15:0] p_dout = '0;

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      cs_seen = cs_seen | ~ext_cs_n;
      if (!ext_rd_n) strb_cnt++;
      if (!ext_wr_n) strb_cnt++;
      if (!ext_wr_n && p_wr) begin
        if (nwr < 2) wlog[nwr] = {23'd0, ext_addr, ext_ub_n, ext_lb_n, ext_dout};
        nwr++;
      end
      if (ext_wr_n && !p_wr) begin
        if (ext_cs_n != p_cs || ext_addr != p_addr || !ext_dout_en || ext_dout != p_dout) hold_bad++;
      end
    end
    p_wr = ext_wr_n; p_cs = ext_cs_n; p_addr = ext_addr; p_dout = ext_dout;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic wr, input logic [22:0] a, input logic [1:0] be,
                         input logic [15:0] wd, input int drop_at,
                         output int lat, output logic [15:0] rd);
    @(negedge clk);
    strb_cnt = 0; nwr = 0; hold_bad = 0; cs_seen = 8'h00;
    wlog[0] = '0; wlog[1] = '0;
    req_write = wr; req_haddr = a; req_be = be; req_wdata = wd; req_valid = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == drop_at) ext_wait = 1'b0;
    end while (!req_ready && lat < 100);
    rd = rsp_rdata;
    req_valid = 1'b0;
    if (lat >= 100) chk("R3 timeout", 64'(lat), 64'd0);
    @(negedge clk);
    chk("R10 ready pulse low after completion", 64'(req_ready), 64'd0);
  endtask

  typedef struct packed {
    logic        wr;
    logic [22:0] ha;
    logic [1:0]  be;
    logic [15:0] wd;
    logic [7:0]  lat;
    logic [3:0]  cs;
    logic [7:0]  strb;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 23'h000008, 2'b11, 16'h0000, 8'd3,  4'd0, 8'd1},
    '{1'b1, 23'h000010, 2'b01, 16'h1234, 8'd3,  4'd0, 8'd1},
    '{1'b0, 23'h200020, 2'b10, 16'h0000, 8'd6,  4'd2, 8'd5},
    '{1'b0, 23'h100004, 2'b11, 16'h0000, 8'd10, 4'd1, 8'd8},
    '{1'b1, 23'h10000B, 2'b10, 16'hABCD, 8'd5,  4'd1, 8'd3},
    '{1'b1, 23'h10000D, 2'b11, 16'h5AA5, 8'd10, 4'd1, 8'd6},
    '{1'b0, 23'h100016, 2'b01, 16'h0000, 8'd5,  4'd1, 8'd4},
    '{1'b0, 23'h700000, 2'b11, 16'h0000, 8'd1,  4'd8, 8'd0},
    '{1'b0, 23'h000018, 2'b00, 16'h0000, 8'd1,  4'd8, 8'd0},
    '{1'b1, 23'h200028, 2'b11, 16'hC3E1, 8'd6,  4'd2, 8'd4}
  };

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int          lat;
    logic [15:0] rd;
    logic [7:0]  exp_cs;
    logic [15:0] exp_rd;
    int          exp_nw;
    logic [63:0] exp_log [2];
    int          k;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", 64'(ext_cs_n), 64'hFF);
    chk("R1 strobes/selects in reset", 64'({ext_rd_n, ext_wr_n, ext_ub_n, ext_lb_n}), 64'hF);
    chk("R1 dout_en/ready in reset", 64'({ext_dout_en, req_ready}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_req(VECS[v].wr, VECS[v].ha, VECS[v].be, VECS[v].wd, 0, lat, rd);
      // R3 R8 latency; R2 decode
      chk($sformatf("R3/R8 latency vec %0d", v), 64'(lat), 64'(VECS[v].lat));
      exp_cs = (VECS[v].cs == 4'd8) ? 8'h00 : (8'h01 << VECS[v].cs);
      chk($sformatf("R2 chip select vec %0d", v), 64'(cs_seen), 64'(exp_cs));
      // R5 strobe length
      chk($sformatf("R5 strobe cycles vec %0d", v), 64'(strb_cnt), 64'(VECS[v].strb));
      if (!VECS[v].wr) begin
        // R11 R6 R7 read data
        exp_rd = (VECS[v].cs == 4'd8) ? 16'h0000 :
                 {(VECS[v].be[1] ? pat(VECS[v].ha, 1'b1) : 8'h00),
                  (VECS[v].be[0] ? pat(VECS[v].ha, 1'b0) : 8'h00)};
        chk($sformatf("R11 read data vec %0d", v), 64'(rd), 64'(exp_rd));
      end else begin
        chk($sformatf("R9 hold after write vec %0d", v), 64'(hold_bad), 64'd0);
        if (cfg_bus16[VECS[v].cs[2:0]]) begin
          exp_nw = 1;
          exp_log[0] = {23'd0, VECS[v].ha, ~VECS[v].be[1], ~VECS[v].be[0], VECS[v].wd};
          chk($sformatf("R6 write lanes vec %0d", v), wlog[0], exp_log[0]);
        end else begin
          exp_nw = 0;
          for (int ln = 0; ln < 2; ln++) begin
            if (VECS[v].be[ln]) begin
              exp_log[exp_nw] = {23'd0, VECS[v].ha, 1'b1, ln[0], 8'h00,
                                 (ln == 1) ? VECS[v].wd[15:8] : VECS[v].wd[7:0]};
              exp_nw++;
            end
          end
          for (int j = 0; j < exp_nw; j++) begin
            chk($sformatf("R7/R8 byte write %0d vec %0d", j, v), wlog[j], exp_log[j]);
          end
        end
        chk($sformatf("R8 write cycle count vec %0d", v), 64'(nwr), 64'(exp_nw));
      end
    end

    // R4: wait pin held past the count, released at cycle 4 -> strobe of 3 cycles
    ext_wait = 1'b1;
    k = 4;
    run_req(1'b0, 23'h000040, 2'b11, 16'h0000, k, lat, rd);
    chk("R4 stretched latency", 64'(lat), 64'd5);
    chk("R4 stretched strobe", 64'(strb_cnt), 64'd3);
    chk("R4 read data after stretch", 64'(rd), 64'({pat(23'h000040, 1'b1), pat(23'h000040, 1'b0)}));
    ext_wait = 1'b0;

    // R2: shadowed chip select 3 becomes reachable when chip select 1 is disabled
    cfg_en = 8'b0000_1101;
    run_req(1'b0, 23'h100008, 2'b11, 16'h0000, 0, lat, rd);
    chk("R2 fallback to next match", 64'(cs_seen), 64'h08);
    chk("R3 latency with five waits", 64'(lat), 64'd8);
    cfg_en = 8'b0000_1111;

    // R10: idle bus after completion
    repeat (2) @(negedge clk);
    chk("R10 idle ready low", 64'(req_ready), 64'd0);
    chk("R1 idle cs released", 64'(ext_cs_n), 64'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule